// File: doc/BRIEF.md
# Toll Lane Transaction Controller

This block sequences one toll payment at a time for an automated lane. A vehicle tag number arrives with a strobe. The controller then waits for the lane to supply the toll amount. It reads that vehicle's stored balance from an on-chip table and checks whether the balance covers the toll. If it does, the controller debits the account and raises the barrier for a set number of cycles, then lowers it. If it does not, the controller refuses the vehicle, the barrier stays down and the stored balance is left as it was.

The transaction walks through seven states: waiting, tag capture, verification, debit, barrier raised, barrier lowering and refusal. Two guard timers bound the wait for the toll amount and the time the barrier may stay up, so the controller never waits forever inside a transaction. A preload port fills the balance table between transactions.

Top module: `toll_gate_ctrl`

## Requirements
- R1: After reset the balance table holds zero in every entry, the controller is waiting, and `gate_open`, `accept`, `reject`, `timeout` and `new_bal` are all 0.
- R2: A `tag_valid` pulse while waiting starts a transaction for `tag_id` (4 bits, selecting one of 16 entries). A `toll_valid` pulse in one of the next TMO cycles captures `toll_amt`. The vehicle is accepted when its stored balance is greater than or equal to the toll; an equal balance passes.
- R3: An acceptance raises `accept` for exactly one cycle. In that cycle `new_bal` shows the balance minus the toll, and that value is written back to the vehicle's entry.
- R4: The barrier opens in the cycle right after `accept` and stays open for `hold_cycles` cycles, where 0 counts as 1 and the count is at most TMO. It is then down for one lowering cycle, after which a new tag is taken.
- R5: A toll larger than the stored balance raises `reject` for exactly one cycle without `timeout`. The barrier never opens and the stored balance is unchanged.
- R6: If no `toll_valid` arrives within TMO cycles of tag capture, `reject` and `timeout` rise together for one cycle and the barrier never opens.
- R7: If `hold_cycles` exceeds TMO, the barrier closes after exactly TMO open cycles and `timeout` pulses in the lowering cycle, with `reject` low.
- R8: A preload write (`pre_we`, `pre_addr`, `pre_data`) updates the table only while the controller is waiting. A preload during a transaction is ignored.
- R9: `tag_valid` pulses during a transaction have no effect on it. At most one of `accept`, `reject` and `gate_open` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tag_valid | input | 1 | Vehicle tag strobe |
| tag_id | input | 4 | Vehicle account index |
| toll_valid | input | 1 | Toll amount strobe |
| toll_amt | input | 16 | Toll to charge |
| hold_cycles | input | 8 | Barrier open time in cycles |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 4 | Preload entry |
| pre_data | input | 16 | Preload balance |
| gate_open | output | 1 | Barrier raise command |
| accept | output | 1 | Transaction accepted pulse |
| reject | output | 1 | Transaction refused pulse |
| timeout | output | 1 | Guard timer expiry pulse |
| new_bal | output | 16 | Remaining balance, valid with accept |

## Verification
The assertions rely on `hold_cycles` staying constant from the debit until the barrier closes. They also rely on every transaction being checked as a complete sequence from tag to return to waiting. The stimulus changes `hold_cycles` only between transactions. During a transaction it adds only tag strobes and preload writes, which the controller must ignore. Random tolls are drawn around each account's shadow balance, so both outcomes and the exact-equality edge occur often.

// File: rtl/toll_pkg.sv
package toll_pkg;

    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_TAG    = 3'd1,
        ST_VERIFY = 3'd2,
        ST_DEBIT  = 3'd3,
        ST_RAISE  = 3'd4,
        ST_LOWER  = 3'd5,
        ST_REFUSE = 3'd6
    } lane_st_e;

    // Outcome flags produced by the sequencer, one per cycle.
    typedef struct packed {
        logic gate;
        logic acc;
        logic rej;
    } lane_out_t;

    function automatic lane_out_t decode_out(lane_st_e s);
        lane_out_t o;
        o.gate = (s == ST_RAISE);
        o.acc  = (s == ST_DEBIT);
        o.rej  = (s == ST_REFUSE);
        return o;
    endfunction

endpackage

// File: rtl/balance_store.sv
module balance_store #(
    parameter int ID_W  = 4,
    parameter int BAL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [ID_W-1:0]  waddr,
    input  logic [BAL_W-1:0] wdata,
    input  logic [ID_W-1:0]  raddr,
    output logic [BAL_W-1:0] rdata
);
    localparam int DEPTH = 1 << ID_W;

    logic [BAL_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/lane_timer.sv
module lane_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/lane_fsm.sv
module lane_fsm
    import toll_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int BAL_W  = 16,
    parameter int HOLD_W = 8,
    parameter int TMO    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tag_valid,
    input  logic [ID_W-1:0]   tag_id,
    input  logic              toll_valid,
    input  logic [BAL_W-1:0]  toll_amt,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic [BAL_W-1:0]  rd_bal,
    output logic [ID_W-1:0]   acct,
    output logic              wr_en,
    output logic [BAL_W-1:0]  wr_data,
    output logic              idle,
    output lane_out_t         flags,
    output logic              timeout
);
    localparam int TMO_BITS = $clog2(TMO + 1);
    localparam int CNT_W    = ((TMO_BITS > HOLD_W) ? TMO_BITS : HOLD_W) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO - 1);

    lane_st_e         st, nxt;
    logic [BAL_W-1:0] amt_q;
    logic             tmo_n;
    logic             clr, inc;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hold_eff;

    lane_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .clr(clr), .inc(inc), .cnt(cnt)
    );

    assign hold_eff = (hold_cycles == '0) ? CNT_W'(1) : CNT_W'(hold_cycles);

    always_comb begin
        nxt   = st;
        tmo_n = 1'b0;
        clr   = 1'b0;
        inc   = 1'b0;
        unique case (st)
            ST_WAIT: begin
                clr = 1'b1;
                if (tag_valid) nxt = ST_TAG;
            end
            ST_TAG: begin
                if (toll_valid) begin
                    nxt = ST_VERIFY;
                    clr = 1'b1;
                end else if (cnt == LAST) begin
                    nxt   = ST_REFUSE;
                    tmo_n = 1'b1;
                end else begin
                    inc = 1'b1;
                end
            end
            ST_VERIFY: nxt = (rd_bal >= amt_q) ? ST_DEBIT : ST_REFUSE;
            ST_DEBIT: begin
                nxt = ST_RAISE;
                clr = 1'b1;
            end
            ST_RAISE: begin
                if ((cnt + CNT_W'(1)) >= hold_eff) begin
                    nxt = ST_LOWER;
                end else if (cnt == LAST) begin
                    nxt   = ST_LOWER;
                    tmo_n = 1'b1;
                end else begin
                    inc = 1'b1;
                end
            end
            ST_LOWER:  nxt = ST_WAIT;
            ST_REFUSE: nxt = ST_WAIT;
            default:   nxt = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_WAIT;
            acct    <= '0;
            amt_q   <= '0;
            timeout <= 1'b0;
        end else begin
            st      <= nxt;
            timeout <= tmo_n;
            if (st == ST_WAIT && tag_valid) acct  <= tag_id;
            if (st == ST_TAG && toll_valid) amt_q <= toll_amt;
        end
    end

    assign flags   = decode_out(st);
    assign idle    = (st == ST_WAIT);
    assign wr_en   = (st == ST_DEBIT);
    assign wr_data = rd_bal - amt_q;
endmodule

// File: rtl/toll_gate_ctrl.sv
module toll_gate_ctrl
    import toll_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int BAL_W  = 16,
    parameter int HOLD_W = 8,
    parameter int TMO    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tag_valid,
    input  logic [ID_W-1:0]   tag_id,
    input  logic              toll_valid,
    input  logic [BAL_W-1:0]  toll_amt,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic              pre_we,
    input  logic [ID_W-1:0]   pre_addr,
    input  logic [BAL_W-1:0]  pre_data,
    output logic              gate_open,
    output logic              accept,
    output logic              reject,
    output logic              timeout,
    output logic [BAL_W-1:0]  new_bal
);
    logic [ID_W-1:0]  acct;
    logic             fsm_we, idle;
    logic [BAL_W-1:0] fsm_wdata, rd_bal;
    lane_out_t        flags;

    logic             mem_we;
    logic [ID_W-1:0]  mem_waddr;
    logic [BAL_W-1:0] mem_wdata;

    lane_fsm #(.ID_W(ID_W), .BAL_W(BAL_W), .HOLD_W(HOLD_W), .TMO(TMO)) u_fsm (
        .clk(clk), .rst(rst),
        .tag_valid(tag_valid), .tag_id(tag_id),
        .toll_valid(toll_valid), .toll_amt(toll_amt),
        .hold_cycles(hold_cycles), .rd_bal(rd_bal),
        .acct(acct), .wr_en(fsm_we), .wr_data(fsm_wdata),
        .idle(idle), .flags(flags), .timeout(timeout)
    );

    assign mem_we    = fsm_we | (pre_we & idle);
    assign mem_waddr = fsm_we ? acct : pre_addr;
    assign mem_wdata = fsm_we ? fsm_wdata : pre_data;

    balance_store #(.ID_W(ID_W), .BAL_W(BAL_W)) u_store (
        .clk(clk), .rst(rst),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(acct), .rdata(rd_bal)
    );

    assign gate_open = flags.gate;
    assign accept    = flags.acc;
    assign reject    = flags.rej;
    assign new_bal   = flags.acc ? fsm_wdata : '0;
endmodule

// File: rtl/toll_gate_chk.sv
module toll_gate_chk #(
    parameter int TMO = 16
) (
    input logic clk,
    input logic rst,
    input logic gate_open,
    input logic accept,
    input logic reject,
    input logic timeout
);
    int unsigned open_run;

    always_ff @(posedge clk) begin
        if (rst)            open_run <= 0;
        else if (gate_open) open_run <= open_run + 1;
        else                open_run <= 0;
    end

    // R4
    debit_then_raise_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> gate_open);

    // R4
    raise_after_debit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_open) |-> $past(accept));

    // R5
    refuse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        reject |=> (!reject && !gate_open && !accept));

    // R3
    accept_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);

    // R9
    exclusive_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({accept, reject, gate_open}));

    // R7
    open_bound_chk: assert property (@(posedge clk) disable iff (rst)
        open_run <= TMO);

    // R7
    timeout_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (timeout && !reject) |-> (!gate_open && $past(gate_open)));

    // R6
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);
endmodule

bind toll_gate_ctrl toll_gate_chk #(.TMO(TMO)) u_chk (
    .clk(clk), .rst(rst), .gate_open(gate_open),
    .accept(accept), .reject(reject), .timeout(timeout)
);

// File: tb/sim_toll_gate_ctrl.sv
module sim_toll_gate_ctrl;
    localparam int ID_W = 4, BAL_W = 16, HOLD_W = 8, TMO = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              tag_valid, toll_valid, pre_we;
    logic [ID_W-1:0]   tag_id, pre_addr;
    logic [BAL_W-1:0]  toll_amt, pre_data;
    logic [HOLD_W-1:0] hold_cycles;
    logic              gate_open, accept, reject, timeout;
    logic [BAL_W-1:0]  new_bal;

    int   checks = 0, errors = 0;
    bit   finished = 0;
    logic [BAL_W-1:0] shadow [16];

    always #4 clk = ~clk;

    toll_gate_ctrl #(.ID_W(ID_W), .BAL_W(BAL_W), .HOLD_W(HOLD_W), .TMO(TMO)) u0 (
        .clk(clk), .rst(rst), .tag_valid(tag_valid), .tag_id(tag_id),
        .toll_valid(toll_valid), .toll_amt(toll_amt), .hold_cycles(hold_cycles),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
        .gate_open(gate_open), .accept(accept), .reject(reject),
        .timeout(timeout), .new_bal(new_bal)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        tag_valid = 0; toll_valid = 0; pre_we = 0;
        tag_id = '0; toll_amt = '0; pre_addr = '0; pre_data = '0;
    endtask

    task automatic preload(input int id, input int val);
        @(negedge clk);
        pre_we = 1; pre_addr = ID_W'(id); pre_data = BAL_W'(val);
        @(negedge clk);
        pre_we = 0;
        shadow[id] = BAL_W'(val);
    endtask

    function automatic int eff_hold(input int h);
        return (h == 0) ? 1 : h;
    endfunction

    // One whole transaction; noise adds ignored tag strobes and preloads.
    task automatic run_txn(input int id, input int amt, input int hold,
                           input int dly, input bit noise);
        bit got_acc = 0, got_rej = 0, tmo_seen = 0, rej_tmo = 0, opened = 0;
        int nb = 0, open_cnt = 0, acc_cyc = -10, first_open = -10, k = 0;
        int he, exp_open;
        bit exp_acc, exp_tmo;
        @(negedge clk);
        hold_cycles = HOLD_W'(hold);
        tag_valid = 1; tag_id = ID_W'(id);
        @(negedge clk);
        tag_valid = 0;
        for (int i = 0; i < 100; i++) begin
            bit fin = 0;
            if (accept) begin got_acc = 1; nb = new_bal; acc_cyc = i; end
            if (gate_open) begin
                if (!opened) first_open = i;
                opened = 1; open_cnt++;
            end
            if (timeout) tmo_seen = 1;
            if (reject) begin got_rej = 1; rej_tmo = timeout; fin = 1; end
            if (opened && !gate_open) fin = 1;
            if (fin) break;
            toll_valid = (k == dly);
            toll_amt   = (k == dly) ? BAL_W'(amt) : BAL_W'($urandom);
            tag_valid  = noise ? 1'($urandom) : 1'b0;
            tag_id     = ID_W'($urandom);
            pre_we     = noise && ($urandom % 3 == 0);
            pre_addr   = ID_W'(id);
            pre_data   = BAL_W'($urandom);
            k++;
            @(negedge clk);
        end
        quiet();
        he = eff_hold(hold);
        if (dly >= TMO) begin
            chk(got_rej, "R6", "reject on missing toll", got_rej, 1);
            chk(rej_tmo, "R6", "timeout with reject", rej_tmo, 1);
            chk(!got_acc && open_cnt == 0, "R6", "barrier open cycles", open_cnt, 0);
        end else begin
            exp_acc = (shadow[id] >= BAL_W'(amt));
            chk(got_acc == exp_acc, "R2", "accept decision", got_acc, exp_acc);
            chk(got_rej == !exp_acc, "R5", "reject decision", got_rej, !exp_acc);
            if (exp_acc) begin
                chk(nb == int'(shadow[id] - BAL_W'(amt)), "R3", "new_bal",
                    nb, shadow[id] - BAL_W'(amt));
                shadow[id] = shadow[id] - BAL_W'(amt);
                chk(first_open == acc_cyc + 1, "R4", "open follows accept",
                    first_open, acc_cyc + 1);
                exp_open = (he > TMO) ? TMO : he;
                exp_tmo  = (he > TMO);
                chk(open_cnt == exp_open, (he > TMO) ? "R7" : "R4",
                    "open cycles", open_cnt, exp_open);
                chk(tmo_seen == exp_tmo, "R7", "open timeout flag", tmo_seen, exp_tmo);
            end else begin
                chk(open_cnt == 0, "R5", "barrier stays down", open_cnt, 0);
                chk(!rej_tmo, "R5", "no timeout on refusal", rej_tmo, 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual expired expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        quiet();
        hold_cycles = 8'd3;
        rst = 1;
        repeat (5) @(negedge clk);
        rst = 0;
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        // R1: outputs idle after reset
        chk({gate_open, accept, reject, timeout} == 4'b0, "R1", "flags after reset",
            {gate_open, accept, reject, timeout}, 0);
        chk(new_bal == 0, "R1", "new_bal after reset", new_bal, 0);
        // R1: cleared table refuses a nonzero toll, accepts a zero toll
        run_txn(3, 1, 2, 0, 0);
        run_txn(3, 0, 2, 0, 0);
        // R8: preload every entry while waiting
        for (int i = 0; i < 16; i++) preload(i, 100 + 37 * i);
        run_txn(5, 0, 1, 1, 0);
        // R2: equal balance passes, R5: one more is refused
        run_txn(2, shadow[2], 2, 0, 0);
        preload(4, 50);
        run_txn(4, 51, 2, 0, 0);
        run_txn(4, 20, 2, 3, 0);              // R5 balance unchanged after refusal
        // R4: hold of zero and exactly TMO; R7: TMO+1 and larger
        run_txn(6, 1, 0, 0, 0);
        run_txn(6, 1, TMO, 0, 0);
        run_txn(6, 1, TMO + 1, 0, 0);
        run_txn(6, 1, 200, 2, 0);
        // R6: last accepted delay, then the expiring one
        run_txn(7, 5, 2, TMO - 1, 0);
        run_txn(7, 5, 2, TMO, 0);
        run_txn(7, 5, 2, 0, 0);
        // R8 and R9: ignored preloads and tag strobes mid-transaction
        for (int n = 0; n < 4; n++) run_txn(8, 10, 3, 2, 1);
        for (int n = 0; n < 50; n++) begin
            int id  = $urandom % 16;
            int amt = int'(shadow[id]) + ($urandom % 21) - 12;
            if (amt < 0) amt = 0;
            if ($urandom % 8 == 0) preload(id, $urandom % 400);
            run_txn(id, amt, $urandom % (TMO + 6), $urandom % (TMO + 2), 1'($urandom));
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule